// File: doc/BRIEF.md
# Lockable clock-control register bank

This block holds the software-visible control state of a clock generator: four clock configuration registers (two clock-control bytes that carry source-select and oscillator-stop bits, a third clock-control byte, and a PLL setting byte), a mode register with interrupt and peripheral-clock enables, and a protect register. The bank drives every stored byte straight out to the clock logic. The oscillators, the PLL and the clock muxes sit outside the block.

Writes are controlled at two levels. The protect register is always writable. Each of its two enable bits opens one group of registers for writing. The mode register also holds a sticky lock bit. Once software sets it, the lock freezes a fixed set of clock fields spread across the configuration registers until the next reset. Blocked fields keep their old value, while the other bits in the same byte still take the written value. While the lock is set, requests to enter wait mode are refused and flagged as errors.

Register addresses: clock-control 0 at 0x06, clock-control 1 at 0x07, protect at 0x0A, clock-control 2 at 0x0C, PLL at 0x1C, mode at 0x1E. Reads come from a combinational mux on the same address bus.

Top module: `clkbank`

## Requirements
- R1: After reset the reads return 0x08 at 0x06, 0x20 at 0x07, 0x00 at 0x0C, 0x12 at 0x1C, 0x01 at 0x1E and 0x00 at 0x0A, and `clk_locked`, `nmi_en`, `slow_pclk_en` and `wait_err` are 0.
- R2: A write to 0x0A always stores data bits [1:0]. A write to 0x06, 0x07, 0x0C or 0x1C takes effect only while protect bit 0 is 1. A write to 0x1E takes effect only while protect bit 1 is 1. Any other write changes nothing.
- R3: Mode bit 1 is the lock. An accepted write with bit 1 = 1 sets it. Writing 0 to it has no effect, and only reset clears it. `clk_locked` shows its value.
- R4: While the lock is 1, accepted writes leave bits 7, 5 and 2 of 0x06, bits 1:0 of 0x07, bit 0 of 0x0C and all of 0x1C unchanged. All other bits of those registers still take the written data.
- R5: Mode bit 4 is stored and drives `nmi_en`. Mode bit 5 is stored and drives `slow_pclk_en`. An accepted write updates both.
- R6: A read of 0x1E always returns 1 in bit 0 and 0 in bits 2, 3, 6 and 7, whatever was written.
- R7: `bus_rdata` is a combinational function of `bus_addr` and the stored state, and it does not depend on the protect or lock state. Unmapped addresses read 0x00. Bits [7:2] of the protect register read 0.
- R8: `wait_ok` equals `wait_req` while unlocked and is 0 while locked. `wait_err` is 1 in the cycle after a clock edge that sampled `wait_req` = 1 with the lock set, and 0 otherwise.
- R9: `clk_ctl0`, `clk_ctl1`, `clk_ctl2` and `pll_ctl` always equal the stored bytes at 0x06, 0x07, 0x0C and 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (5) | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| wait_req | input | 1 | Request to enter wait mode |
| wait_ok | output | 1 | Wait request granted |
| wait_err | output | 1 | Wait was requested while locked |
| clk_ctl0 | output | 8 | Clock-control 0 byte (source select, oscillator stop) |
| clk_ctl1 | output | 8 | Clock-control 1 byte |
| clk_ctl2 | output | 8 | Clock-control 2 byte |
| pll_ctl | output | 8 | PLL setting byte |
| nmi_en | output | 1 | Non-maskable interrupt enable |
| slow_pclk_en | output | 1 | Low-speed peripheral clock delivery enable |
| clk_locked | output | 1 | Sticky clock-configuration lock |

## Verification
The assertions assume that `bus_addr`, `bus_we`, `bus_wdata` and `wait_req` are stable and known around each rising edge, and that reset is the only way the lock returns to 0. The stability checks on locked fields depend on that second point. The bench changes every input only on the falling edge. It resets between random rounds so that both locked and unlocked phases are covered. It also sets the lock only rarely during random writes, so that the protect gating is exercised before the freeze takes hold.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

    localparam int DW = 8;

    // Register addresses (the mode register address is fixed by the system map)
    localparam logic [7:0] A_CTL0 = 8'h06;
    localparam logic [7:0] A_CTL1 = 8'h07;
    localparam logic [7:0] A_PROT = 8'h0A;
    localparam logic [7:0] A_CTL2 = 8'h0C;
    localparam logic [7:0] A_PLL  = 8'h1C;
    localparam logic [7:0] A_MODE = 8'h1E;

    localparam int NCREG = 4;
    // Index 0 = ctl0 ... index 3 = pll, packed low to high
    localparam logic [NCREG*8-1:0] CREG_ADDRS = {A_PLL, A_CTL2, A_CTL1, A_CTL0};

    // Mode register bit positions
    localparam int MB_FIXED1 = 0;
    localparam int MB_LOCK   = 1;
    localparam int MB_NMI    = 4;
    localparam int MB_PCLK   = 5;

    typedef struct packed {
        logic       clk_en;
        logic       mode_en;
    } guard_t;

    typedef struct packed {
        logic lock;
        logic nmi;
        logic pclk;
        logic werr;
    } mode_t;

endpackage

// File: rtl/clkbank_guard.sv
module clkbank_guard
    import clkbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] wdata,
    output logic       clk_wen_ok,
    output logic       mode_wen_ok,
    output logic [1:0] prot_bits
);
    guard_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.clk_en  = wdata[0];
            st_d.mode_en = wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_wen_ok  = st_q.clk_en;
    assign mode_wen_ok = st_q.mode_en;
    assign prot_bits   = {st_q.mode_en, st_q.clk_en};
endmodule

// File: rtl/clkbank_creg.sv
module clkbank_creg #(
    parameter int              W     = 8,
    parameter logic [W-1:0]    RST   = '0,
    parameter logic [W-1:0]    LMASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         lock,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } creg_t;

    creg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (lock) st_d.val = (st_q.val & LMASK) | (wdata & ~LMASK);
            else      st_d.val = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{val: RST};
        else        st_q <= st_d;
    end

    assign q = st_q.val;
endmodule

// File: rtl/clkbank_mode.sv
module clkbank_mode
    import clkbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       wait_req,
    output logic       lock,
    output logic       nmi,
    output logic       pclk,
    output logic       werr,
    output logic       wait_ok,
    output logic [7:0] rd_byte
);
    mode_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.werr = wait_req & st_q.lock;
        if (wr) begin
            st_d.lock = st_q.lock | wdata[MB_LOCK];
            st_d.nmi  = wdata[MB_NMI];
            st_d.pclk = wdata[MB_PCLK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_byte            = '0;
        rd_byte[MB_FIXED1] = 1'b1;
        rd_byte[MB_LOCK]   = st_q.lock;
        rd_byte[MB_NMI]    = st_q.nmi;
        rd_byte[MB_PCLK]   = st_q.pclk;
    end

    assign lock    = st_q.lock;
    assign nmi     = st_q.nmi;
    assign pclk    = st_q.pclk;
    assign werr    = st_q.werr;
    assign wait_ok = wait_req & ~st_q.lock;
endmodule

// File: rtl/clkbank.sv
module clkbank
    import clkbank_pkg::*;
#(
    parameter int                    ADDR_W    = 5,
    parameter logic [NCREG*8-1:0]    CREG_RST  = {8'h12, 8'h00, 8'h20, 8'h08},
    parameter logic [NCREG*8-1:0]    CREG_LOCK = {8'hFF, 8'h01, 8'h03, 8'hA4}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              wait_req,
    output logic              wait_ok,
    output logic              wait_err,
    output logic [7:0]        clk_ctl0,
    output logic [7:0]        clk_ctl1,
    output logic [7:0]        clk_ctl2,
    output logic [7:0]        pll_ctl,
    output logic              nmi_en,
    output logic              slow_pclk_en,
    output logic              clk_locked
);
    logic [ADDR_W-1:0] creg_addr [NCREG];
    logic [7:0]        creg_q    [NCREG];
    logic [NCREG-1:0]  creg_hit;
    logic              prot_hit, mode_hit;
    logic              clk_wen_ok, mode_wen_ok;
    logic [1:0]        prot_q;
    logic [7:0]        mode_rd;
    logic              lock_q;

    assign prot_hit = (bus_addr == ADDR_W'(A_PROT));
    assign mode_hit = (bus_addr == ADDR_W'(A_MODE));

    clkbank_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_we & prot_hit),
        .wdata      (bus_wdata[1:0]),
        .clk_wen_ok (clk_wen_ok),
        .mode_wen_ok(mode_wen_ok),
        .prot_bits  (prot_q)
    );

    clkbank_mode u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_we & mode_hit & mode_wen_ok),
        .wdata   (bus_wdata),
        .wait_req(wait_req),
        .lock    (lock_q),
        .nmi     (nmi_en),
        .pclk    (slow_pclk_en),
        .werr    (wait_err),
        .wait_ok (wait_ok),
        .rd_byte (mode_rd)
    );

    for (genvar i = 0; i < NCREG; i++) begin : g_creg
        assign creg_addr[i] = ADDR_W'(CREG_ADDRS[i*8 +: 8]);
        assign creg_hit[i]  = (bus_addr == creg_addr[i]);
        clkbank_creg #(
            .W    (8),
            .RST  (CREG_RST[i*8 +: 8]),
            .LMASK(CREG_LOCK[i*8 +: 8])
        ) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .wr   (bus_we & creg_hit[i] & clk_wen_ok),
            .lock (lock_q),
            .wdata(bus_wdata),
            .q    (creg_q[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCREG; i++) begin
            if (creg_hit[i]) bus_rdata = creg_q[i];
        end
        if (prot_hit) bus_rdata = {6'b0, prot_q};
        if (mode_hit) bus_rdata = mode_rd;
    end

    assign clk_ctl0   = creg_q[0];
    assign clk_ctl1   = creg_q[1];
    assign clk_ctl2   = creg_q[2];
    assign pll_ctl    = creg_q[3];
    assign clk_locked = lock_q;
endmodule

// File: rtl/clkbank_chk.sv
module clkbank_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              wait_req,
    input logic              wait_ok,
    input logic              wait_err,
    input logic [7:0]        clk_ctl0,
    input logic [7:0]        clk_ctl1,
    input logic [7:0]        pll_ctl,
    input logic              clk_locked,
    input logic [1:0]        prot_q
);
    localparam logic [ADDR_W-1:0] AD_CTL0 = ADDR_W'(8'h06);
    localparam logic [ADDR_W-1:0] AD_CTL1 = ADDR_W'(8'h07);
    localparam logic [ADDR_W-1:0] AD_PLL  = ADDR_W'(8'h1C);
    localparam logic [ADDR_W-1:0] AD_MODE = ADDR_W'(8'h1E);

    // R2: clock registers do not move without the protect enable
    p_prot_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AD_PLL && !prot_q[0]) |=> $stable(pll_ctl));

    // R3: lock is sticky until reset
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_locked |=> clk_locked);

    // R4: locked fields hold across writes
    p_lock_pll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AD_PLL && clk_locked) |=> $stable(pll_ctl));

    p_lock_ctl0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AD_CTL0 && clk_locked)
        |=> ((clk_ctl0 & 8'hA4) == ($past(clk_ctl0) & 8'hA4)));

    p_lock_ctl1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AD_CTL1 && clk_locked)
        |=> ((clk_ctl1 & 8'h03) == ($past(clk_ctl1) & 8'h03)));

    // R6: fixed bits of the mode register on readback
    p_mode_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AD_MODE) |-> (bus_rdata[0] && ((bus_rdata & 8'hCC) == 8'h00)));

    // R8: no wait grant while locked, error flag follows a refused request
    p_wait_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_locked |-> !wait_ok);

    p_wait_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && clk_locked) |=> wait_err);

    p_wait_noerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wait_req && clk_locked) |=> !wait_err);
endmodule

bind clkbank clkbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .wait_req  (wait_req),
    .wait_ok   (wait_ok),
    .wait_err  (wait_err),
    .clk_ctl0  (clk_ctl0),
    .clk_ctl1  (clk_ctl1),
    .pll_ctl   (pll_ctl),
    .clk_locked(clk_locked),
    .prot_q    (prot_q)
);

// File: tb/clkbank_test.sv
module clkbank_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_we;
    logic [4:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       wait_req, wait_ok, wait_err;
    logic [7:0] clk_ctl0, clk_ctl1, clk_ctl2, pll_ctl;
    logic       nmi_en, slow_pclk_en, clk_locked;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Reference model state
    logic [7:0] m_reg [4];   // ctl0, ctl1, ctl2, pll
    logic [1:0] m_prot;
    logic       m_lock, m_nmi, m_pclk, m_werr;

    always #(PERIOD/2) clk = ~clk;

    clkbank uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wait_req(wait_req),
        .wait_ok(wait_ok), .wait_err(wait_err), .clk_ctl0(clk_ctl0),
        .clk_ctl1(clk_ctl1), .clk_ctl2(clk_ctl2), .pll_ctl(pll_ctl),
        .nmi_en(nmi_en), .slow_pclk_en(slow_pclk_en), .clk_locked(clk_locked)
    );

    function automatic int reg_index(input logic [4:0] a);
        case (a)
            5'h06: return 0;
            5'h07: return 1;
            5'h0C: return 2;
            5'h1C: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] lock_mask(input int idx);
        case (idx)
            0: return 8'hA4;
            1: return 8'h03;
            2: return 8'h01;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] model_read(input logic [4:0] a);
        int idx = reg_index(a);
        if (idx >= 0)   return m_reg[idx];
        if (a == 5'h0A) return {6'b0, m_prot};
        if (a == 5'h1E) return {2'b00, m_pclk, m_nmi, 2'b00, m_lock, 1'b1};
        return 8'h00;
    endfunction

    task automatic model_reset();
        m_reg[0] = 8'h08; m_reg[1] = 8'h20; m_reg[2] = 8'h00; m_reg[3] = 8'h12;
        m_prot = 2'b00; m_lock = 0; m_nmi = 0; m_pclk = 0; m_werr = 0;
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        vectors++;
        cmp(tag, "rdata", bus_rdata, model_read(bus_addr));
        cmp("R9", "clk_ctl0", clk_ctl0, m_reg[0]);
        cmp("R9", "clk_ctl1", clk_ctl1, m_reg[1]);
        cmp("R9", "clk_ctl2", clk_ctl2, m_reg[2]);
        cmp("R9", "pll_ctl", pll_ctl, m_reg[3]);
        cmp("R3", "clk_locked", {7'b0, clk_locked}, {7'b0, m_lock});
        cmp("R5", "nmi_en", {7'b0, nmi_en}, {7'b0, m_nmi});
        cmp("R5", "slow_pclk_en", {7'b0, slow_pclk_en}, {7'b0, m_pclk});
        cmp("R8", "wait_ok", {7'b0, wait_ok}, {7'b0, wait_req & ~m_lock});
        cmp("R8", "wait_err", {7'b0, wait_err}, {7'b0, m_werr});
    endtask

    // Drive on falling edge, check, then apply the rising edge to the model
    task automatic step(input string tag, input logic we, input logic [4:0] a,
                        input logic [7:0] d, input logic w);
        int idx;
        bus_we = we; bus_addr = a; bus_wdata = d; wait_req = w;
        #1;
        check_all(tag);
        @(posedge clk);
        m_werr = w & m_lock;
        if (we) begin
            idx = reg_index(a);
            if (a == 5'h0A) m_prot = d[1:0];
            else if (a == 5'h1E && m_prot[1]) begin
                m_lock = m_lock | d[1];
                m_nmi  = d[4];
                m_pclk = d[5];
            end else if (idx >= 0 && m_prot[0]) begin
                if (m_lock) m_reg[idx] = (m_reg[idx] & lock_mask(idx)) | (d & ~lock_mask(idx));
                else        m_reg[idx] = d;
            end
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        bus_we = 0; bus_addr = '0; bus_wdata = '0; wait_req = 0;
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic expect_read(input string tag, input logic [4:0] a, input logic [7:0] exp);
        bus_we = 0; bus_addr = a; wait_req = 0;
        #1;
        vectors++;
        cmp(tag, "literal read", bus_rdata, exp);
        step(tag, 0, a, 8'h00, 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired (all requirements): actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [4:0] alist [7];
        alist = '{5'h06, 5'h07, 5'h0A, 5'h0C, 5'h1C, 5'h1E, 5'h03};
        @(negedge clk);
        do_reset();

        // R1 reset values
        expect_read("R1", 5'h06, 8'h08);
        expect_read("R1", 5'h07, 8'h20);
        expect_read("R1", 5'h0C, 8'h00);
        expect_read("R1", 5'h1C, 8'h12);
        expect_read("R1", 5'h1E, 8'h01);
        expect_read("R1", 5'h0A, 8'h00);

        // R2 writes ignored without protect enable
        step("R2", 1, 5'h06, 8'hFF, 0);
        step("R2", 1, 5'h1E, 8'h30, 0);
        expect_read("R2", 5'h06, 8'h08);
        expect_read("R2", 5'h1E, 8'h01);
        // R2 open clock group only
        step("R2", 1, 5'h0A, 8'hFD, 0);
        expect_read("R7", 5'h0A, 8'h01);
        step("R2", 1, 5'h06, 8'hFF, 0);
        step("R2", 1, 5'h1C, 8'h5A, 0);
        step("R2", 1, 5'h1E, 8'h30, 0);
        expect_read("R2", 5'h06, 8'hFF);
        expect_read("R2", 5'h1E, 8'h01);

        // R5 / R6 mode fields
        step("R2", 1, 5'h0A, 8'h03, 0);
        step("R5", 1, 5'h1E, 8'hFD, 0);
        expect_read("R6", 5'h1E, 8'h31);
        step("R8", 0, 5'h03, 8'h00, 1);   // wait granted while unlocked

        // R3 set lock, then try to clear it
        step("R3", 1, 5'h07, 8'hFF, 0);
        step("R3", 1, 5'h1E, 8'h02, 0);
        expect_read("R3", 5'h1E, 8'h03);
        step("R3", 1, 5'h1E, 8'h10, 0);
        expect_read("R3", 5'h1E, 8'h13);

        // R4 locked fields hold, others update
        step("R4", 1, 5'h06, 8'h00, 0);
        expect_read("R4", 5'h06, 8'hA4);
        step("R4", 1, 5'h07, 8'h00, 0);
        expect_read("R4", 5'h07, 8'h03);
        step("R4", 1, 5'h0C, 8'hFE, 0);
        expect_read("R4", 5'h0C, 8'hFE);
        step("R4", 1, 5'h1C, 8'h00, 0);
        expect_read("R4", 5'h1C, 8'h5A);

        // R8 wait refused while locked
        step("R8", 0, 5'h03, 8'h00, 1);
        step("R8", 0, 5'h03, 8'h00, 0);

        // R7 reads independent of protect, unmapped reads zero
        step("R7", 1, 5'h0A, 8'h00, 0);
        expect_read("R7", 5'h06, 8'hA4);
        expect_read("R7", 5'h15, 8'h00);

        // R1 / R3 reset clears lock
        do_reset();
        expect_read("R1", 5'h1E, 8'h01);
        expect_read("R1", 5'h1C, 8'h12);

        // Random rounds compared against the model every cycle
        for (int round = 0; round < 6; round++) begin
            do_reset();
            for (int n = 0; n < 500; n++) begin
                logic [4:0] a;
                logic [7:0] d;
                a = alist[$urandom_range(0, 6)];
                d = 8'($urandom);
                if (a == 5'h1E && $urandom_range(0, 15) != 0) d[1] = 1'b0;
                step("R7", $urandom_range(0, 1) == 1, a, d, $urandom_range(0, 3) == 0);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule